// File: doc/BRIEF.md
# Cascadable programmable delay stage

This block is a cycle-accurate model of a digitally programmed delay element. A one-bit signal enters, passes one fixed register, and then travels down a tapped shift line; a binary-weighted tap code chooses how many further clock steps it spends there before it reaches the output. The tap code and a separate chain bit are held in a bank of storage cells. These cells follow the bus while the hold input is low and keep their contents while it is high.

Two override inputs force the bank regardless of hold. The minimum override empties it, giving the shortest path. The maximum override loads a fixed pattern and adds one whole unit of delay, so the result sits one step above the largest code. The stored chain bit drives a complementary output pair. Wiring the true output back to this stage's maximum override, and the inverted output to the next stage's minimum override, lets identical stages be chained: each added stage costs one extra bus line. A blanking input holds the output low.

Top module: `pdc_stage`

## Requirements
- R1: During reset the stored code and chain bit are zero, `sig_out` is 0, `chain_out` is 0 and `chain_out_n` is 1.
- R2: While `hold` is low and no override is active, the bank takes `bus_code` and `bus_chain` at each rising clock edge.
- R3: While `hold` is high and no override is active, the bank keeps its contents and bus changes have no effect on the delay.
- R4: `bus_code` bit i weighs 2^i clock steps (bit 0 = 1 step, bit 6 = 64 steps). A pulse reaches `sig_out` 1 + code clock edges after it is presented.
- R5: While `force_min` is high, the code, chain bit and bonus unit are cleared whatever `hold` and the bus do, so the latency is 1 edge.
- R6: While `force_max` is high (and `force_min` low), code bits 0 and 1 are cleared, bits 2 to 6 and the chain bit are set, and one unit (4 steps) is added. That gives 128 steps and a latency of 129 edges, whatever `hold` and the bus do.
- R7: When both overrides are high, the minimum override wins.
- R8: `chain_out` equals the stored chain bit and `chain_out_n` is its inverse.
- R9: While `blank` is high, `sig_out` is 0.
- R10: The delay never decreases as the effective code (chain bit as the next higher weight) rises. The all-ones code gives 127 steps, and the maximum override gives 128.
- R11: In a two-stage chain the end-to-end latency is 2 + steps of stage one + steps of stage two. Stage two is held at 0 steps while stage one's chain bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Signal to be delayed |
| bus_code | input | 7 | Binary-weighted tap code |
| bus_chain | input | 1 | Chain request bit |
| hold | input | 1 | High keeps the stored code, low follows the bus |
| force_min | input | 1 | Forces the minimum delay |
| force_max | input | 1 | Forces the maximum delay |
| blank | input | 1 | High forces `sig_out` low |
| sig_out | output | 1 | Delayed signal |
| chain_out | output | 1 | Stored chain bit |
| chain_out_n | output | 1 | Inverse of the stored chain bit |

## Verification
The bank update can face both overrides together with a transparent `hold`. In a chain this happens naturally once stage one's chain bit rises and feeds back into its own maximum override. The bench provokes it on stage two: it raises that stage's maximum override while stage one still holds it at minimum, with `hold` low and a busy bus. It then judges the outcome purely by the measured pulse latency and the chain outputs, which must show the minimum path.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [1:0] {
        FORCE_NONE = 2'd0,
        FORCE_MIN  = 2'd1,
        FORCE_MAX  = 2'd2
    } force_e;

    // Minimum override has priority over maximum.
    function automatic force_e resolve_force(input logic fmin, input logic fmax);
        if (fmin)      return FORCE_MIN;
        else if (fmax) return FORCE_MAX;
        else           return FORCE_NONE;
    endfunction

endpackage

// File: rtl/pdc_latch_bank.sv
module pdc_latch_bank
    import pdc_pkg::*;
#(
    parameter int CODE_W = 7,
    parameter int FRAC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              force_min,
    input  logic              force_max,
    input  logic [CODE_W-1:0] bus_code,
    input  logic              bus_chain,
    output logic [CODE_W-1:0] code_q,
    output logic              chain_q,
    output logic              bonus_q
);

    localparam logic [CODE_W-1:0] MAX_PATTERN = {CODE_W{1'b1}} << FRAC_W;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              chain;
        logic              bonus;
    } bank_t;

    bank_t  bank_d, bank_q;
    force_e mode;

    always_comb begin
        mode   = resolve_force(force_min, force_max);
        bank_d = bank_q;
        unique case (mode)
            FORCE_MIN: begin
                bank_d.code  = '0;
                bank_d.chain = 1'b0;
                bank_d.bonus = 1'b0;
            end
            FORCE_MAX: begin
                bank_d.code  = MAX_PATTERN;
                bank_d.chain = 1'b1;
                bank_d.bonus = 1'b1;
            end
            default: begin
                if (!hold) begin
                    bank_d.code  = bus_code;
                    bank_d.chain = bus_chain;
                    bank_d.bonus = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign code_q  = bank_q.code;
    assign chain_q = bank_q.chain;
    assign bonus_q = bank_q.bonus;

    AST_PASS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !force_min && !force_max) |=> (code_q == $past(bus_code) && chain_q == $past(bus_chain))); // R2

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !force_min && !force_max) |=> ($stable(code_q) && $stable(chain_q) && $stable(bonus_q))); // R3

    AST_MIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        force_min |=> (code_q == '0 && !chain_q && !bonus_q)); // R5

    AST_MAX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (force_max && !force_min) |=> (code_q == MAX_PATTERN && chain_q && bonus_q)); // R6

endmodule

// File: rtl/pdc_step_sel.sv
module pdc_step_sel #(
    parameter int CODE_W = 7,
    parameter int FRAC_W = 2,
    parameter int STEP_W = CODE_W + 1
) (
    input  logic [CODE_W-1:0] code,
    input  logic              bonus,
    output logic [STEP_W-1:0] steps
);

    localparam logic [STEP_W-1:0] UNIT_STEPS = STEP_W'(1) << FRAC_W;

    logic [STEP_W-1:0] term [CODE_W];

    for (genvar i = 0; i < CODE_W; i++) begin : g_weight
        assign term[i] = code[i] ? (STEP_W'(1) << i) : '0;
    end

    always_comb begin
        steps = bonus ? UNIT_STEPS : '0;
        for (int k = 0; k < CODE_W; k++) begin
            steps = steps + term[k];
        end
    end

endmodule

// File: rtl/pdc_delay_line.sv
module pdc_delay_line #(
    parameter int DEPTH  = 129,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [STEP_W-1:0] sel,
    output logic              dout
);

    typedef struct packed {
        logic [DEPTH-1:0] taps;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d      = line_q;
        line_d.taps = {line_q.taps[DEPTH-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign dout = (int'(sel) < DEPTH) ? line_q.taps[sel] : 1'b0;

    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel) < DEPTH); // R10

endmodule

// File: rtl/pdc_stage.sv
module pdc_stage #(
    parameter int CODE_W = 7,
    parameter int FRAC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_in,
    input  logic [CODE_W-1:0] bus_code,
    input  logic              bus_chain,
    input  logic              hold,
    input  logic              force_min,
    input  logic              force_max,
    input  logic              blank,
    output logic              sig_out,
    output logic              chain_out,
    output logic              chain_out_n
);

    localparam int STEP_W    = CODE_W + 1;
    localparam int MAX_STEPS = 1 << CODE_W;
    localparam int DEPTH     = MAX_STEPS + 1;

    logic [CODE_W-1:0] code_q;
    logic              chain_q;
    logic              bonus_q;
    logic [STEP_W-1:0] steps;
    logic              line_out;

    pdc_latch_bank #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .force_min (force_min),
        .force_max (force_max),
        .bus_code  (bus_code),
        .bus_chain (bus_chain),
        .code_q    (code_q),
        .chain_q   (chain_q),
        .bonus_q   (bonus_q)
    );

    pdc_step_sel #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_sel (
        .code  (code_q),
        .bonus (bonus_q),
        .steps (steps)
    );

    pdc_delay_line #(.DEPTH(DEPTH), .STEP_W(STEP_W)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sig_in),
        .sel   (steps),
        .dout  (line_out)
    );

    assign sig_out     = line_out & ~blank;
    assign chain_out   = chain_q;
    assign chain_out_n = ~chain_q;

    AST_BLANK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> !sig_out); // R9

    AST_MIN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (force_min && force_max) |=> (!chain_out && steps == '0)); // R7

    AST_MAX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (force_max && !force_min) |=> (int'(steps) == MAX_STEPS)); // R6

endmodule

// File: tb/sim_pdc_stage.sv
module sim_pdc_stage;

    localparam int CLK_PERIOD = 10;
    localparam int WINDOW     = 400;
    localparam int NVEC       = 14;
    // {chain bit, tap code}, ordered by rising effective code
    localparam logic [7:0] VEC [NVEC] = '{
        8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h08, 8'h10,
        8'h20, 8'h40, 8'h7F, 8'h80, 8'h81, 8'hD5, 8'hFF
    };

    logic clk = 1'b0;
    logic rst_n;
    logic sig_in;
    logic [6:0] bus_code;
    logic bus_chain1, bus_chain2;
    logic hold, fmin1, fmax2, blank1, blank2;
    logic out1, out2, co1, co1_n, co2, co2_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pdc_stage u0 (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .bus_code(bus_code),
        .bus_chain(bus_chain1), .hold(hold), .force_min(fmin1), .force_max(co1),
        .blank(blank1), .sig_out(out1), .chain_out(co1), .chain_out_n(co1_n)
    );

    pdc_stage u1 (
        .clk(clk), .rst_n(rst_n), .sig_in(out1), .bus_code(bus_code),
        .bus_chain(bus_chain2), .hold(hold), .force_min(co1_n), .force_max(fmax2),
        .blank(blank2), .sig_out(out2), .chain_out(co2), .chain_out_n(co2_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sig_in = 1'b0; hold = 1'b0; fmin1 = 1'b0; fmax2 = 1'b0;
        blank1 = 1'b0; blank2 = 1'b0; bus_code = '0; bus_chain1 = 1'b0; bus_chain2 = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic measure(output int n1, output int n2);
        @(negedge clk);
        sig_in = 1'b1;
        n1 = -1; n2 = -1;
        for (int c = 1; c <= WINDOW; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c == 1) sig_in = 1'b0;
            if (n1 < 0 && out1) n1 = c;
            if (n2 < 0 && out2) n2 = c;
        end
    endtask

    function automatic int exp_first(input logic [7:0] v);
        return v[7] ? 129 : 1 + int'(v[6:0]);
    endfunction

    function automatic int exp_total(input logic [7:0] v);
        return v[7] ? 130 + int'(v[6:0]) : 2 + int'(v[6:0]);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n1, n2, prev;
        rst_n = 1'b0; sig_in = 1'b0; hold = 1'b0; fmin1 = 1'b0; fmax2 = 1'b0;
        blank1 = 1'b0; blank2 = 1'b0; bus_code = 7'h55; bus_chain1 = 1'b1; bus_chain2 = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 sig_out", int'(out1), 0);
        check("R1 chain_out", int'(co1), 0);
        check("R1 chain_out_n", int'(co1_n), 1);

        // Vector table: R4 weights, R8 chain pair, R10 order, R11 cascade
        prev = 0;
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            bus_code = VEC[i][6:0]; bus_chain1 = VEC[i][7];
            repeat (4) @(negedge clk);
            hold = 1'b1;
            repeat (2) @(negedge clk);
            check("R8 chain_out", int'(co1), int'(VEC[i][7]));
            check("R8 chain_out_n", int'(co1_n), int'(!VEC[i][7]));
            measure(n1, n2);
            check(VEC[i][7] ? "R6 stage one at max" : "R4 stage one latency", n1, exp_first(VEC[i]));
            check("R11 chain latency", n2, exp_total(VEC[i]));
            if (n2 < prev) check("R10 monotonic", n2, prev);
            else           check("R10 monotonic", 1, 1);
            prev = n2;
        end

        // R3: hold high ignores bus change; R2: hold low loads
        do_reset();
        bus_code = 7'd5;
        repeat (3) @(negedge clk);
        hold = 1'b1; bus_code = 7'd100;
        repeat (3) @(negedge clk);
        measure(n1, n2);
        check("R3 held code", n1, 6);
        hold = 1'b0; bus_code = 7'd9;
        repeat (2) @(negedge clk);
        hold = 1'b1;
        measure(n1, n2);
        check("R2 loaded code", n1, 10);

        // R5: minimum override beats a transparent bank and the bus
        do_reset();
        fmin1 = 1'b1; bus_code = 7'd50; bus_chain1 = 1'b1;
        repeat (4) @(negedge clk);
        check("R5 chain cleared", int'(co1), 0);
        measure(n1, n2);
        check("R5 min latency", n1, 1);

        // R7: both overrides on stage two (stage one chain bit low)
        do_reset();
        bus_code = 7'd20; fmax2 = 1'b1;
        repeat (4) @(negedge clk);
        measure(n1, n2);
        check("R7 min wins", n2, 22);

        // R6: maximum override on stage two alone
        do_reset();
        bus_code = 7'd3; bus_chain1 = 1'b1;
        repeat (4) @(negedge clk);
        fmax2 = 1'b1; bus_code = 7'd0;
        repeat (3) @(negedge clk);
        hold = 1'b1; fmax2 = 1'b0;
        repeat (2) @(negedge clk);
        measure(n1, n2);
        check("R6 forced max stage two", n2, 258);

        // R9: blanking keeps the output low
        do_reset();
        blank1 = 1'b1; bus_code = 7'd2;
        repeat (3) @(negedge clk);
        measure(n1, n2);
        check("R9 blanked", n1, -1);
        blank1 = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule